// File: doc/BRIEF.md
# Chunk Commit Order Arbiter

This block orders the commits of up to eight processors that each execute code in atomic chunks. A processor raises its request line once its chunk is complete and holds it until a single-cycle grant comes back; only then may the chunk commit. Grants are issued one at a time, so all commits across the machine form one total order.

Three modes decide who wins. In capture mode a rotating priority picks among the current requesters, and every grant also emits the winner's processor number as a 4-bit entry on an outgoing log stream. In playback mode an incoming log stream supplies the processor number that must commit next, and only that processor is granted; one entry is consumed per grant, so a captured commit order is reproduced exactly. In fixed-rotation mode neither stream is used, and processors are granted strictly in ascending number order, wrapping around. The log storage itself sits outside the block, behind valid/ready handshakes.

Top module: `commit_sequencer`

## Requirements
- R1: After reset `gnt` is all zero, `rec_valid` is 0, `rep_ready` is 0, and both the capture priority pointer and the fixed-rotation pointer are at processor 0.
- R2: `gnt` has at most one bit set, each grant lasts exactly one cycle, the cycle after a grant carries no grant, and a grant only goes to a processor whose request was high in the cycle before the grant appears.
- R3: In capture mode (`mode` = 0) the winner is the first requester found searching upward from the priority pointer with wraparound; after a grant the pointer moves to the winner's number plus one, modulo the processor count.
- R4: In capture mode each grant appears on the same clock edge as `rec_valid` = 1 with `rec_id` equal to the winner's number in plain binary; the entry stays stable until taken with `rec_ready` = 1.
- R5: In capture mode no grant is issued while an entry is pending with `rec_ready` = 0; when `rec_ready` returns, a waiting request is granted on that same edge as the pending entry leaves.
- R6: In playback mode (`mode` = 1) a grant goes only to the processor numbered by `rep_id` while `rep_valid` = 1; `rep_ready` is high in the cycle before that grant appears, and exactly one entry is consumed per grant.
- R7: In playback mode, if the processor named at the head of the log is not requesting, or `rep_valid` is 0, nobody is granted and `rep_ready` stays 0, whatever the other processors request.
- R8: In fixed-rotation mode (`mode` = 2 or 3) grants follow processor 0, 1, ... N-1, 0, ...; the arbiter waits while the processor whose turn it is does not request, and it never raises `rec_valid` or `rep_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 capture, 1 playback, 2 or 3 fixed rotation |
| req | input | NPROC | Commit request, one bit per processor, held until granted |
| gnt | output | NPROC | One-cycle commit grant, one-hot or zero |
| rec_valid | output | 1 | Captured log entry available |
| rec_id | output | ID_W | Captured processor number |
| rec_ready | input | 1 | Log storage accepts the captured entry |
| rep_valid | input | 1 | Playback log head entry available |
| rep_id | input | ID_W | Processor number at the playback log head |
| rep_ready | output | 1 | Playback log head consumed on this edge |

## Verification
A corrupted capture pointer shows up as a wrong winner on the very next grant taken from a multi-requester pattern, so the bench sweeps every request mask and predicts each winner arithmetically. A wrong rotation pointer or a dropped playback pop shows within one grant as a grant to the wrong processor, or as a hang where the named processor sits waiting. A lost log handshake shows in the cycle after the grant, as a missing, unstable or overwritten `rec_id`.

// File: rtl/commit_sequencer.sv
module commit_sequencer #(
  parameter int NPROC = 8,
  parameter int ID_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic [NPROC-1:0] req,
  output logic [NPROC-1:0] gnt,
  output logic             rec_valid,
  output logic [ID_W-1:0]  rec_id,
  input  logic             rec_ready,
  input  logic             rep_valid,
  input  logic [ID_W-1:0]  rep_id,
  output logic             rep_ready
);

  localparam int PW = (NPROC > 1) ? $clog2(NPROC) : 1;

  logic [PW-1:0] rr_ptr, rot_ptr, rr_win, win;
  logic          rr_hit, rep_hit, rot_hit, take;
  logic          is_rec, is_rep, is_rot, busy, rec_free;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (int'(p) == NPROC - 1) ? '0 : p + 1'b1;
  endfunction

  assign is_rec   = (mode == 2'd0);
  assign is_rep   = (mode == 2'd1);
  assign is_rot   = mode[1];
  assign busy     = |gnt;
  assign rec_free = !rec_valid || rec_ready;

  always_comb begin
    int j;
    rr_hit = 1'b0;
    rr_win = '0;
    for (int k = 0; k < NPROC; k++) begin
      j = (int'(rr_ptr) + k) % NPROC;
      if (!rr_hit && req[j]) begin
        rr_hit = 1'b1;
        rr_win = PW'(j);
      end
    end
  end

  assign rep_hit = rep_valid && (int'(rep_id) < NPROC) && req[PW'(rep_id)];
  assign rot_hit = req[rot_ptr];

  always_comb begin
    take = 1'b0;
    win  = rot_ptr;
    if (!busy) begin
      if (is_rec) begin
        take = rr_hit && rec_free;
        win  = rr_win;
      end else if (is_rep) begin
        take = rep_hit;
        win  = PW'(rep_id);
      end else begin
        take = rot_hit;
      end
    end
  end

  assign rep_ready = take && is_rep;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt       <= '0;
      rr_ptr    <= '0;
      rot_ptr   <= '0;
      rec_valid <= 1'b0;
      rec_id    <= '0;
    end else begin
      gnt <= take ? (NPROC'(1) << win) : '0;
      if (take && is_rec) rr_ptr <= nxt(rr_win);
      if (take && is_rot) rot_ptr <= nxt(rot_ptr);
      if (take && is_rec) begin
        rec_valid <= 1'b1;
        rec_id    <= ID_W'(rr_win);
      end else if (rec_ready) begin
        rec_valid <= 1'b0;
      end
    end
  end

  initial begin
    id_width_chk: assert (NPROC <= (1 << ID_W));
  end

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R2
  gnt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |=> (gnt == '0));

  // R2
  gnt_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt) |-> ((gnt & ~$past(req)) == '0));

  // R4
  rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> (rec_valid && $stable(rec_id)));

  // R5
  rec_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready && mode == 2'd0) |=> (gnt == '0));

  // R6
  rep_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ready |=> (gnt == (NPROC'(1) << $past(PW'(rep_id)))));

  // R7
  rep_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !rep_valid) |=> (gnt == '0));

  // R8
  rot_nolog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !rec_valid) |=> (!rec_valid && !rep_ready));

endmodule

// File: tb/commit_sequencer_tb.sv
`timescale 1ns/1ps
module commit_sequencer_tb;
  localparam int NP = 8;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic [NP-1:0] req = '0;
  logic [NP-1:0] gnt;
  logic          rec_valid;
  logic [IW-1:0] rec_id;
  logic          rec_ready = 1'b1;
  logic          rep_valid = 1'b0;
  logic [IW-1:0] rep_id = '0;
  logic          rep_ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  commit_sequencer #(.NPROC(NP), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .req(req), .gnt(gnt),
    .rec_valid(rec_valid), .rec_id(rec_id), .rec_ready(rec_ready),
    .rep_valid(rep_valid), .rep_id(rep_id), .rep_ready(rep_ready));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [NP-1:0] m, input int p);
    for (int k = 0; k < NP; k++) if (m[(p + k) % NP]) return (p + k) % NP;
    return -1;
  endfunction

  function automatic int seq(input int i);
    return (i * 5 + i / 3) % NP;
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  int rr_exp = 0;

  task automatic drain_capture(input logic [NP-1:0] start);
    logic [NP-1:0] pend;
    int guard, w;
    bit prev;
    pend = start;
    req = pend;
    guard = 0;
    prev = 1'b0;
    while (pend != '0 && guard < 40) begin
      step();
      guard++;
      if (gnt != '0) begin
        w = pick(pend, rr_exp);
        chk("R2", "spacing", int'(prev), 0);
        chk("R3", "capture winner", int'(gnt), int'(NP'(1) << w));
        chk("R4", "rec_valid", int'(rec_valid), 1);
        chk("R4", "rec_id", int'(rec_id), w);
        pend &= ~gnt;
        req = pend;
        rr_exp = (w + 1) % NP;
        prev = 1'b1;
      end else prev = 1'b0;
    end
    chk("R3", "drain finished", int'(pend), 0);
    step();
    step();
    chk("R4", "entry taken", int'(rec_valid), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] clr;
    int w1, w2, idx, got, guard, exp_rot;
    bit popped;

    do_reset();
    // R1 reset state
    chk("R1", "gnt after reset", int'(gnt), 0);
    chk("R1", "rec_valid after reset", int'(rec_valid), 0);
    chk("R1", "rep_ready after reset", int'(rep_ready), 0);

    // R3 R4 R2: sweep of every request mask in capture mode
    mode = 2'd0;
    rec_ready = 1'b1;
    rr_exp = 0;
    for (int m = 1; m < (1 << NP); m++) drain_capture(NP'(m));

    // R5 R4: backpressure on the outgoing log
    rec_ready = 1'b0;
    req = 8'b1010_0101;
    step();
    w1 = pick(8'b1010_0101, rr_exp);
    chk("R3", "first winner under stall", int'(gnt), int'(NP'(1) << w1));
    req &= ~gnt;
    rr_exp = (w1 + 1) % NP;
    for (int c = 0; c < 5; c++) begin
      step();
      chk("R5", "no grant while entry pending", int'(gnt), 0);
      chk("R4", "pending entry held", int'(rec_id), w1);
      chk("R4", "pending valid held", int'(rec_valid), 1);
    end
    rec_ready = 1'b1;
    step();
    w2 = pick(req, rr_exp);
    chk("R5", "grant once ready returns", int'(gnt), int'(NP'(1) << w2));
    chk("R5", "new entry", int'(rec_id), w2);
    req &= ~gnt;
    rr_exp = (w2 + 1) % NP;
    drain_capture(req);

    // R1: pointer back at 0 after reset
    do_reset();
    mode = 2'd0;
    req = 8'b1000_0001;
    step();
    chk("R1", "capture pointer reset", int'(gnt), 1);
    req = '0;
    step();
    step();

    // R6 R7: playback of a computed log, processors re-request after a grant
    mode = 2'd1;
    req = '1;
    idx = 0;
    got = 0;
    rep_valid = 1'b1;
    rep_id = IW'(seq(0));
    clr = '0;
    popped = 1'b0;
    guard = 0;
    #1;
    popped = rep_ready;
    while (got < 24 && guard < 400) begin
      step();
      guard++;
      chk("R2", "onehot playback", int'($countones(gnt) <= 1), 1);
      if (gnt != '0) begin
        chk("R6", "playback grant", int'(gnt), int'(NP'(1) << seq(got)));
        got++;
      end
      chk("R6", "pop matches grant", int'(gnt != '0), int'(popped));
      req |= clr;
      clr = gnt;
      req &= ~gnt;
      if (popped) idx++;
      rep_valid = (idx < 24);
      rep_id = IW'(seq(idx));
      #1;
      popped = rep_ready;
      if (gnt == '0 && rep_valid)
        chk("R7", "ready follows head request", int'(rep_ready), int'(req[seq(idx)]));
    end
    chk("R6", "entries consumed", idx, 24);
    chk("R6", "grants issued", got, 24);
    step();
    chk("R6", "no grant after log ends", int'(gnt), 0);

    // R7: head processor not requesting
    rep_valid = 1'b1;
    rep_id = IW'(6);
    req = 8'b1011_1111;
    for (int c = 0; c < 6; c++) begin
      #1;
      chk("R7", "no pop while head idle", int'(rep_ready), 0);
      step();
      chk("R7", "no grant while head idle", int'(gnt), 0);
    end
    rep_valid = 1'b0;
    req = '1;
    for (int c = 0; c < 4; c++) begin
      step();
      chk("R7", "no grant with empty log", int'(gnt), 0);
    end
    rep_valid = 1'b1;
    #1;
    chk("R6", "pop for head", int'(rep_ready), 1);
    step();
    chk("R6", "head granted", int'(gnt), 8'b0100_0000);
    rep_valid = 1'b0;
    req = '0;
    step();

    // R8: fixed rotation, mode 2 then mode 3, no log traffic
    mode = 2'd2;
    rep_valid = 1'b1;
    rep_id = IW'(3);
    req = '1;
    clr = '0;
    exp_rot = 0;
    got = 0;
    guard = 0;
    while (got < 24 && guard < 200) begin
      step();
      guard++;
      if (got == 12) mode = 2'd3;
      chk("R8", "no capture entry", int'(rec_valid), 0);
      if (gnt != '0) begin
        chk("R8", "rotation order", int'(gnt), int'(NP'(1) << exp_rot));
        exp_rot = (exp_rot + 1) % NP;
        got++;
      end
      req |= clr;
      clr = gnt;
      req &= ~gnt;
      #1;
      chk("R8", "no playback pop", int'(rep_ready), 0);
    end
    chk("R8", "rotation grants", got, 24);

    // R8: wait for the processor whose turn it is
    step();
    req = '1;
    req[exp_rot] = 1'b0;
    for (int c = 0; c < 6; c++) begin
      step();
      chk("R8", "rotation waits", int'(gnt), 0);
    end
    req[exp_rot] = 1'b1;
    step();
    chk("R8", "turn holder granted", int'(gnt), int'(NP'(1) << exp_rot));
    rep_valid = 1'b0;

    // R1: rotation pointer back at 0 after reset
    do_reset();
    mode = 2'd2;
    req = '1;
    step();
    chk("R1", "rotation pointer reset", int'(gnt), 1);
    req = '0;
    step();

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule